// File: doc/BRIEF.md
# Predicate Register File with Commit Gating

This block holds the one-bit condition flags that steer conditional execution. The flags are updated by compare-type results, and each issued instruction consults one flag, its qualifying predicate, to decide whether its result is kept. Two read ports give flag values to downstream logic. A third lookup takes the qualifying-predicate index of the instruction being issued and drives two signals. The first is a commit enable for the instruction's result. The second is a filtered exception signal, which is raised only for instructions whose predicate is true.

Flag 0 is wired to read true on every lookup, and writes aimed at it are dropped. An instruction that names no predicate uses index 0, so it always commits. Reads are combinational. A read in the same cycle as a write to the same entry sees the value being written, except for entry 0, which always reads 1. Two write ports may update flags in the same cycle. If both name the same entry, write port 1 wins.

Top module: `pred_commit_rf`

## Requirements
- R1: The file has 64 entries of one bit each, addressed by a 6-bit index. A value written to entry k (k from 1 to 63) is returned by every later read of k until k is written again.
- R2: Index 0 returns 1 on both read ports and on the qualifying-predicate lookup, in every cycle, including a cycle in which a write targets index 0.
- R3: A write of 0 to index 0 on either write port leaves index 0 reading 1 in all later cycles.
- R4: When issue_valid_i is 1 and the qualifying predicate is 1, commit_o is 1 and exc_o equals exc_i.
- R5: When the qualifying predicate is 0, commit_o is 0 and exc_o is 0, whatever the value of exc_i.
- R6: If both write ports are enabled for the same nonzero index in one cycle, the stored value is the value on write port 1.
- R7: While rst_ni is low, and afterwards until a write occurs, entries 1 to 63 read 0.
- R8: A read of a nonzero index in the same cycle as an enabled write to that index returns the value being written. Write port 1 has priority if both ports write that index.
- R9: With qp_idx_i = 0 and issue_valid_i = 1, commit_o is 1.
- R10: Writes to two different nonzero indices on the two ports in one cycle both take effect.
- R11: When issue_valid_i is 0, commit_o and exc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr0_en_i | input | 1 | Write port 0 enable |
| wr0_idx_i | input | 6 | Write port 0 index |
| wr0_val_i | input | 1 | Write port 0 data |
| wr1_en_i | input | 1 | Write port 1 enable (priority) |
| wr1_idx_i | input | 6 | Write port 1 index |
| wr1_val_i | input | 1 | Write port 1 data |
| rd0_idx_i | input | 6 | Read port 0 index |
| rd0_val_o | output | 1 | Read port 0 value |
| rd1_idx_i | input | 6 | Read port 1 index |
| rd1_val_o | output | 1 | Read port 1 value |
| issue_valid_i | input | 1 | An instruction is issued this cycle |
| qp_idx_i | input | 6 | Qualifying-predicate index of the issued instruction |
| exc_i | input | 1 | Exception raised by the issued instruction |
| qp_val_o | output | 1 | Value of the qualifying predicate |
| commit_o | output | 1 | Result commit enable |
| exc_o | output | 1 | Exception after predicate filtering |

## Verification
A read and a write can name the same entry in the same cycle. The bench sets up this collision with both ports writing one index, and also with a write to index 0, while reads and the predicate lookup point at the same index. It then checks the combinational outputs before the clock edge: the written value must appear for a nonzero index, and 1 must appear for index 0. It checks the stored result after the edge, which must follow port 1 and leave entry 0 unchanged.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned PRED_NUM = 64;
  localparam int unsigned PRED_IDX_W = $clog2(PRED_NUM);
endpackage

// File: rtl/pred_store.sv
module pred_store #(
  parameter int unsigned NUM = pred_pkg::PRED_NUM,
  localparam int unsigned IW = $clog2(NUM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr0_en_i,
  input  logic [IW-1:0] wr0_idx_i,
  input  logic          wr0_val_i,
  input  logic          wr1_en_i,
  input  logic [IW-1:0] wr1_idx_i,
  input  logic          wr1_val_i,
  output logic [NUM-1:0] state_o
);
  // entry 0 has no storage
  logic [NUM-1:1] mem_q, mem_d;

  for (genvar i = 1; i < NUM; i++) begin : g_ent
    logic hit0, hit1;
    assign hit0 = wr0_en_i && (wr0_idx_i == IW'(i));
    assign hit1 = wr1_en_i && (wr1_idx_i == IW'(i));
    assign mem_d[i] = hit1 ? wr1_val_i : (hit0 ? wr0_val_i : mem_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else         mem_q <= mem_d;
  end

  assign state_o = {mem_q, 1'b1};

  p_port1_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0_en_i && wr1_en_i && wr0_idx_i == wr1_idx_i && wr1_idx_i != '0)
    |=> state_o[$past(wr1_idx_i)] == $past(wr1_val_i));

  p_write_sticks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1_en_i && wr1_idx_i != '0) |=> state_o[$past(wr1_idx_i)] == $past(wr1_val_i));

  p_zero_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0_en_i && wr0_idx_i == '0) |=> state_o[0]);
endmodule

// File: rtl/pred_lookup.sv
module pred_lookup #(
  parameter int unsigned NUM = pred_pkg::PRED_NUM,
  localparam int unsigned IW = $clog2(NUM)
) (
  input  logic [NUM-1:0] state_i,
  input  logic [IW-1:0]  idx_i,
  input  logic           wr0_en_i,
  input  logic [IW-1:0]  wr0_idx_i,
  input  logic           wr0_val_i,
  input  logic           wr1_en_i,
  input  logic [IW-1:0]  wr1_idx_i,
  input  logic           wr1_val_i,
  output logic           val_o
);
  always_comb begin
    if (idx_i == '0)                             val_o = 1'b1;
    else if (wr1_en_i && wr1_idx_i == idx_i)     val_o = wr1_val_i;
    else if (wr0_en_i && wr0_idx_i == idx_i)     val_o = wr0_val_i;
    else                                         val_o = state_i[idx_i];
  end
endmodule

// File: rtl/pred_gate.sv
module pred_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_valid_i,
  input  logic qp_i,
  input  logic exc_i,
  output logic commit_o,
  output logic exc_o
);
  assign commit_o = issue_valid_i & qp_i;
  assign exc_o    = commit_o & exc_i;

  p_false_mutes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qp_i |-> !commit_o && !exc_o);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_i |-> !commit_o && !exc_o);
endmodule

// File: rtl/pred_commit_rf.sv
module pred_commit_rf #(
  parameter int unsigned NUM = pred_pkg::PRED_NUM,
  localparam int unsigned IW = $clog2(NUM),
  localparam int unsigned NLOOK = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr0_en_i,
  input  logic [IW-1:0] wr0_idx_i,
  input  logic          wr0_val_i,
  input  logic          wr1_en_i,
  input  logic [IW-1:0] wr1_idx_i,
  input  logic          wr1_val_i,
  input  logic [IW-1:0] rd0_idx_i,
  output logic          rd0_val_o,
  input  logic [IW-1:0] rd1_idx_i,
  output logic          rd1_val_o,
  input  logic          issue_valid_i,
  input  logic [IW-1:0] qp_idx_i,
  input  logic          exc_i,
  output logic          qp_val_o,
  output logic          commit_o,
  output logic          exc_o
);
  logic [NUM-1:0]  state;
  logic [IW-1:0]   look_idx [NLOOK];
  logic [NLOOK-1:0] look_val;

  pred_store #(.NUM(NUM)) u_store (
    .clk_i, .rst_ni,
    .wr0_en_i, .wr0_idx_i, .wr0_val_i,
    .wr1_en_i, .wr1_idx_i, .wr1_val_i,
    .state_o(state)
  );

  assign look_idx[0] = rd0_idx_i;
  assign look_idx[1] = rd1_idx_i;
  assign look_idx[2] = qp_idx_i;

  for (genvar l = 0; l < NLOOK; l++) begin : g_look
    pred_lookup #(.NUM(NUM)) u_look (
      .state_i(state), .idx_i(look_idx[l]),
      .wr0_en_i, .wr0_idx_i, .wr0_val_i,
      .wr1_en_i, .wr1_idx_i, .wr1_val_i,
      .val_o(look_val[l])
    );
  end

  assign rd0_val_o = look_val[0];
  assign rd1_val_o = look_val[1];
  assign qp_val_o  = look_val[2];

  pred_gate u_gate (
    .clk_i, .rst_ni, .issue_valid_i,
    .qp_i(qp_val_o), .exc_i, .commit_o, .exc_o
  );

  p_zero_true_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_idx_i == '0) |-> rd0_val_o);
  p_nopred_commits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && qp_idx_i == '0) |-> commit_o);
  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1_en_i && wr1_idx_i != '0 && rd1_idx_i == wr1_idx_i) |-> rd1_val_o == wr1_val_i);
  p_exc_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && qp_val_o) |-> commit_o && (exc_o == exc_i));
endmodule

// File: tb/tb_pred_commit_rf.sv
module tb_pred_commit_rf;
  logic clk = 0, rst_ni = 0;
  logic wr0_en = 0, wr0_val = 0, wr1_en = 0, wr1_val = 0;
  logic [5:0] wr0_idx = 0, wr1_idx = 0, rd0_idx = 0, rd1_idx = 0, qp_idx = 0;
  logic issue = 0, exc = 0;
  logic rd0_val, rd1_val, qp_val, commit, exc_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pred_commit_rf dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr0_en_i(wr0_en), .wr0_idx_i(wr0_idx), .wr0_val_i(wr0_val),
    .wr1_en_i(wr1_en), .wr1_idx_i(wr1_idx), .wr1_val_i(wr1_val),
    .rd0_idx_i(rd0_idx), .rd0_val_o(rd0_val),
    .rd1_idx_i(rd1_idx), .rd1_val_o(rd1_val),
    .issue_valid_i(issue), .qp_idx_i(qp_idx), .exc_i(exc),
    .qp_val_o(qp_val), .commit_o(commit), .exc_o(exc_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_clear();
    wr0_en = 0; wr1_en = 0;
  endtask

  // drive at negedge, settle, optionally check, then next negedge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 1; i < 64; i++) begin
      rd0_idx = 6'(i); #1;
      if (rd0_val !== 1'b0) bad++;
    end
    chk("R7 entries cleared", bad == 0, 1'b1);
    rd0_idx = 0; rd1_idx = 0; qp_idx = 0; #1;
    chk("R2 rd0 idx0", rd0_val, 1'b1);
    chk("R2 rd1 idx0", rd1_val, 1'b1);
    chk("R2 qp idx0", qp_val, 1'b1);
  endtask

  task automatic t_dual_write();
    wr0_en = 1; wr0_idx = 5;  wr0_val = 1;
    wr1_en = 1; wr1_idx = 40; wr1_val = 1;
    step(); wr_clear();
    rd0_idx = 5; rd1_idx = 40; #1;
    chk("R10 port0 entry", rd0_val, 1'b1);
    chk("R10 port1 entry", rd1_val, 1'b1);
    wr0_en = 1; wr0_idx = 63; wr0_val = 1;
    step(); wr_clear();
    step();
    rd0_idx = 63; rd1_idx = 62; #1;
    chk("R1 top entry held", rd0_val, 1'b1);
    chk("R1 neighbour untouched", rd1_val, 1'b0);
    wr1_en = 1; wr1_idx = 63; wr1_val = 0;
    step(); wr_clear(); #1;
    chk("R1 overwrite", rd0_val, 1'b0);
  endtask

  task automatic t_bypass();
    rd0_idx = 7; rd1_idx = 7; qp_idx = 7;
    wr0_en = 1; wr0_idx = 7; wr0_val = 1; #1;
    chk("R8 rd0 sees port0 write", rd0_val, 1'b1);
    chk("R8 qp sees port0 write", qp_val, 1'b1);
    wr1_en = 1; wr1_idx = 7; wr1_val = 0; #1;
    chk("R8 port1 priority in bypass", rd1_val, 1'b0);
    step(); wr_clear(); #1;
    chk("R6 stored port1 value", rd0_val, 1'b0);
  endtask

  task automatic t_priority();
    rd0_idx = 9;
    wr0_en = 1; wr0_idx = 9; wr0_val = 0;
    wr1_en = 1; wr1_idx = 9; wr1_val = 1;
    step(); wr_clear(); #1;
    chk("R6 port1 writes 1", rd0_val, 1'b1);
    wr0_en = 1; wr0_idx = 9; wr0_val = 1;
    wr1_en = 1; wr1_idx = 9; wr1_val = 0;
    step(); wr_clear(); #1;
    chk("R6 port1 writes 0", rd0_val, 1'b0);
  endtask

  task automatic t_zero();
    rd0_idx = 0; rd1_idx = 0; qp_idx = 0; issue = 1; exc = 0;
    wr0_en = 1; wr0_idx = 0; wr0_val = 0;
    wr1_en = 1; wr1_idx = 0; wr1_val = 0; #1;
    chk("R2 no bypass on idx0", rd0_val, 1'b1);
    chk("R9 commit during zero write", commit, 1'b1);
    step(); wr_clear(); #1;
    chk("R3 idx0 after write", rd1_val, 1'b1);
    chk("R9 nopred commits", commit, 1'b1);
    issue = 0;
  endtask

  task automatic t_commit();
    wr0_en = 1; wr0_idx = 20; wr0_val = 1;
    step(); wr_clear();
    issue = 1; qp_idx = 20; exc = 1; #1;
    chk("R4 commit true", commit, 1'b1);
    chk("R4 exc passed", exc_out, 1'b1);
    exc = 0; #1;
    chk("R4 no exc", exc_out, 1'b0);
    qp_idx = 21; exc = 1; #1;
    chk("R5 commit false", commit, 1'b0);
    chk("R5 exc muted", exc_out, 1'b0);
    issue = 0; qp_idx = 20; #1;
    chk("R11 idle commit", commit, 1'b0);
    chk("R11 idle exc", exc_out, 1'b0);
    exc = 0;
  endtask

  task automatic t_rereset();
    rst_ni = 0; rd0_idx = 5; rd1_idx = 40; #1;
    chk("R7 reset clears 5", rd0_val, 1'b0);
    chk("R7 reset clears 40", rd1_val, 1'b0);
    step(); rst_ni = 1; step();
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_ni = 1; step();
    t_reset();
    t_dual_write();
    t_bypass();
    t_priority();
    t_zero();
    t_commit();
    t_rereset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule